// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block places a small mailbox window in a host's memory-mapped register space and uses it to reach a private 32-bit register space that the host cannot address directly. The host loads a target address and, for stores, a data word. It then writes a command asking for a read or a write. The bridge issues one request on a request/acknowledge port whose latency can vary. When the access completes, the bridge raises an acknowledge flag in the command register, and a read result appears in the read-data register.

The handshake has two phases. The acknowledge flag and the read result stay put until the host writes a clear to the command register. The bridge then drops back to idle, and the command register reads as zero only from that point on, so a host that polls for zero knows the bridge can take a new command. Only one transaction is handled at a time. Targets outside the private space, targets that are not word aligned, and commands that ask for both a read and a write are acknowledged at once and never reach the private port.

Top module: `regwin_bridge`

## Requirements
- R1: The window decodes four 32-bit registers at byte offsets 0x0 (command), 0x4 (target address), 0x8 (read data) and 0xC (write data) from a base set by parameter WIN_BASE (default 0x400). Address bits [1:0] are ignored. A host read returns its data, with a valid strobe, one clock after the read enable. A read outside the window returns zero, and a write outside the window changes nothing.
- R2: The command register has bit 0 = read request, bit 1 = write request and bit 2 = acknowledge, and all other bits read 0. It reads exactly zero from reset and whenever the bridge is idle. While a transaction runs it reads back the request bits. Once the transaction completes it reads back the request bits with bit 2 set.
- R3: In idle, a command with only bit 0 set and a valid target issues one private request with the write flag low and the target address. The read-data register takes the private data, and acknowledge is set at the clock edge where the private acknowledge is sampled.
- R4: In idle, a command with only bit 1 set and a valid target issues one private request with the write flag high, the target address and the write-data register contents.
- R5: Acknowledge, the request bits and the read-data register hold for as long as the host leaves the command register alone. A host write with bits [1:0] both zero returns the bridge to idle, and the command register reads zero one cycle later.
- R6: A command written while a private request is outstanding, or written with any request bit set while acknowledge is set, is ignored, and the command register keeps its value.
- R7: A target with any bit above bit 11 set, or with bits [1:0] not zero, issues no private request. Acknowledge is set one cycle after the command. Writes are dropped, and a read loads zero into the read-data register.
- R8: A command with both bit 0 and bit 1 set issues no private request and sets acknowledge one cycle later. The read-data register keeps its value.
- R9: Host writes to the read-data register have no effect. It changes only when a read completes.
- R10: The private request stays asserted, with address, write flag and data unchanged, until the private acknowledge is sampled. It drops on that edge, and at most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_rd_en | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd_en |
| priv_req | output | 1 | Private-side request, held until acknowledged |
| priv_we | output | 1 | Private-side write flag |
| priv_addr | output | PRIV_AW | Private-side byte address |
| priv_wdata | output | DW | Private-side write data |
| priv_ack | input | 1 | Private-side one-cycle completion pulse |
| priv_rdata | input | DW | Private-side read data, valid with priv_ack |

## Verification
Completion of a private access and a host write to the command register can land on the same clock edge. The bridge must finish the access and discard the host's command. The bench provokes this collision by fixing the responder's latency and writing a fresh command on every cycle of a transaction, so one of those writes is sure to coincide with the acknowledge. A behavioural model then judges, cycle by cycle, the command readback, the request pins and the captured read data. Directed checks confirm afterwards that acknowledge is set, that the result matches the responder's storage, and that no second request was issued.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int CMD_RD_BIT  = 0;
  localparam int CMD_WR_BIT  = 1;
  localparam int CMD_ACK_BIT = 2;

  localparam int NREG     = 4;
  localparam int IDX_CMD  = 0;
  localparam int IDX_ADDR = 1;
  localparam int IDX_RDAT = 2;
  localparam int IDX_WDAT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/regwin_host_dec.sv
module regwin_host_dec
  import regwin_pkg::*;
#(
  parameter int          HOST_AW  = 16,
  parameter int          DW       = 32,
  parameter int unsigned WIN_BASE = 32'h400
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr_en,
  input  logic                     host_rd_en,
  input  logic [HOST_AW-1:0]       host_addr,
  input  logic [NREG-1:0][DW-1:0]  reg_view,
  output logic [NREG-1:0]          wr_stb,
  output logic [DW-1:0]            host_rdata,
  output logic                     host_rvalid
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [HOST_AW-1:0] BASE_V = HOST_AW'(WIN_BASE);

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (host_addr[HOST_AW-1:IDX_W+2] == BASE_V[HOST_AW-1:IDX_W+2]);
  assign idx = host_addr[IDX_W+1:2];

  for (genvar i = 0; i < NREG; i++) begin : g_stb
    assign wr_stb[i] = host_wr_en && hit && (idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_rd_en;
      if (host_rd_en)
        host_rdata <= hit ? reg_view[idx] : '0;
    end
  end
endmodule

// File: rtl/regwin_data_regs.sv
module regwin_data_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_we,
  input  logic          wdat_we,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] wdat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      if (addr_we) addr_q <= host_wdata;
      if (wdat_we) wdat_q <= host_wdata;
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PRIV_AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_val,
  input  logic [DW-1:0] addr_q,
  input  logic          priv_ack,
  input  logic [DW-1:0] priv_rdata,
  output logic          launch,
  output logic          launch_we,
  output logic [DW-1:0] cmd_view,
  output logic [DW-1:0] rdat_q
);
  win_state_e state;
  logic [1:0] op_q;
  logic       any_op, both_op, addr_bad, clr_req;

  assign any_op   = cmd_val[CMD_RD_BIT] | cmd_val[CMD_WR_BIT];
  assign both_op  = cmd_val[CMD_RD_BIT] & cmd_val[CMD_WR_BIT];
  assign addr_bad = (|addr_q[DW-1:PRIV_AW]) | (|addr_q[1:0]);
  assign clr_req  = cmd_wr && !any_op;

  assign launch    = (state == ST_IDLE) && cmd_wr && any_op && !both_op && !addr_bad;
  assign launch_we = cmd_val[CMD_WR_BIT];

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_RD_BIT]  = op_q[0];
    cmd_view[CMD_WR_BIT]  = op_q[1];
    cmd_view[CMD_ACK_BIT] = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= 2'b00;
      rdat_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_wr && any_op) begin
            op_q <= {cmd_val[CMD_WR_BIT], cmd_val[CMD_RD_BIT]};
            if (both_op) begin
              state <= ST_DONE;
            end else if (addr_bad) begin
              state <= ST_DONE;
              if (cmd_val[CMD_RD_BIT]) rdat_q <= '0;
            end else begin
              state <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (priv_ack) begin
            state <= ST_DONE;
            if (op_q == 2'b01) rdat_q <= priv_rdata;
          end
        end
        ST_DONE: begin
          if (clr_req) begin
            state <= ST_IDLE;
            op_q  <= 2'b00;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) && !clr_req |=> (state == ST_DONE) && $stable(rdat_q) && $stable(op_q));

  // R6
  busy_cmd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY) && !priv_ack |=> (state == ST_BUSY) && $stable(op_q));

  // R7
  bad_addr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && cmd_wr && cmd_val[CMD_RD_BIT] && !cmd_val[CMD_WR_BIT] && addr_bad
    |=> (state == ST_DONE) && (rdat_q == '0));

  // R8
  both_bits_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && cmd_wr && both_op |=> (state == ST_DONE) && $stable(rdat_q));
endmodule

// File: rtl/regwin_priv_mst.sv
module regwin_priv_mst #(
  parameter int DW      = 32,
  parameter int PRIV_AW = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               launch_we,
  input  logic [DW-1:0]      addr_q,
  input  logic [DW-1:0]      wdat_q,
  input  logic               priv_ack,
  output logic               priv_req,
  output logic               priv_we,
  output logic [PRIV_AW-1:0] priv_addr,
  output logic [DW-1:0]      priv_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      priv_req   <= 1'b0;
      priv_we    <= 1'b0;
      priv_addr  <= '0;
      priv_wdata <= '0;
    end else if (launch) begin
      priv_req   <= 1'b1;
      priv_we    <= launch_we;
      priv_addr  <= addr_q[PRIV_AW-1:0];
      priv_wdata <= wdat_q;
    end else if (priv_ack) begin
      priv_req <= 1'b0;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    priv_req && !priv_ack |=> priv_req && $stable(priv_addr) && $stable(priv_we) && $stable(priv_wdata));

  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    priv_req && priv_ack |=> !priv_req);

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    !(launch && priv_req));

  // R10
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    priv_ack |-> priv_req);
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          HOST_AW  = 16,
  parameter int unsigned WIN_BASE = 32'h400,
  parameter int          PRIV_AW  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_rvalid,
  output logic               priv_req,
  output logic               priv_we,
  output logic [PRIV_AW-1:0] priv_addr,
  output logic [DW-1:0]      priv_wdata,
  input  logic               priv_ack,
  input  logic [DW-1:0]      priv_rdata
);
  logic [NREG-1:0]         wr_stb;
  logic [NREG-1:0][DW-1:0] reg_view;
  logic [DW-1:0]           addr_q, wdat_q, rdat_q, cmd_view;
  logic                    launch, launch_we;

  assign reg_view[IDX_CMD]  = cmd_view;
  assign reg_view[IDX_ADDR] = addr_q;
  assign reg_view[IDX_RDAT] = rdat_q;
  assign reg_view[IDX_WDAT] = wdat_q;

  regwin_host_dec #(.HOST_AW(HOST_AW), .DW(DW), .WIN_BASE(WIN_BASE)) u_dec (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .reg_view(reg_view), .wr_stb(wr_stb),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  regwin_data_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr_we(wr_stb[IDX_ADDR]), .wdat_we(wr_stb[IDX_WDAT]),
    .host_wdata(host_wdata), .addr_q(addr_q), .wdat_q(wdat_q)
  );

  regwin_ctrl #(.DW(DW), .PRIV_AW(PRIV_AW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(wr_stb[IDX_CMD]), .cmd_val(host_wdata),
    .addr_q(addr_q), .priv_ack(priv_ack), .priv_rdata(priv_rdata),
    .launch(launch), .launch_we(launch_we), .cmd_view(cmd_view), .rdat_q(rdat_q)
  );

  regwin_priv_mst #(.DW(DW), .PRIV_AW(PRIV_AW)) u_mst (
    .clk(clk), .rst(rst), .launch(launch), .launch_we(launch_we),
    .addr_q(addr_q), .wdat_q(wdat_q), .priv_ack(priv_ack),
    .priv_req(priv_req), .priv_we(priv_we), .priv_addr(priv_addr),
    .priv_wdata(priv_wdata)
  );

  // R9
  rdat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb[IDX_RDAT] && !priv_ack && !launch && !wr_stb[IDX_CMD] |=> $stable(rdat_q));
endmodule

// File: tb/regwin_bridge_tb.sv
module regwin_bridge_tb_top;
  localparam logic [15:0] B = 16'h0400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        priv_req, priv_we;
  logic [11:0] priv_addr;
  logic [31:0] priv_wdata;
  logic        priv_ack = 1'b0;
  logic [31:0] priv_rdata = '0;

  int checks = 0, errors = 0, req_count = 0, fixed_lat = -1;
  bit finished = 0;

  always #2 clk = ~clk;

  regwin_bridge dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .priv_req(priv_req), .priv_we(priv_we),
    .priv_addr(priv_addr), .priv_wdata(priv_wdata), .priv_ack(priv_ack),
    .priv_rdata(priv_rdata)
  );

  // behavioural responder with storage
  logic [31:0] mem [0:1023];
  int wait_cnt = 0;
  bit rsp_active = 0;
  bit prev_req = 0;
  always @(negedge clk) begin
    if (priv_ack) priv_ack <= 1'b0;
    else if (!rst && priv_req) begin
      if (!rsp_active) begin
        rsp_active = 1;
        wait_cnt = (fixed_lat >= 0) ? fixed_lat : int'($urandom_range(0, 5));
      end
      if (wait_cnt == 0) begin
        priv_ack <= 1'b1;
        priv_rdata <= mem[priv_addr[11:2]];
        if (priv_we) mem[priv_addr[11:2]] = priv_wdata;
        rsp_active = 0;
      end else wait_cnt--;
    end
    if (!rst && priv_req && !prev_req) req_count++;
    prev_req = priv_req;
  end

  // reference model
  int          m_st = 0;
  logic [1:0]  m_op = 0;
  logic [31:0] m_addr = 0, m_wdata = 0, m_rdata = 0, m_hrdata = 0, m_pwdata = 0;
  logic [11:0] m_paddr = 0;
  bit          m_req = 0, m_pwe = 0, m_rv = 0;

  function automatic logic [31:0] m_cmd();
    return {29'd0, (m_st == 2), m_op};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_op = 0; m_addr = 0; m_wdata = 0; m_rdata = 0;
      m_req = 0; m_rv = 0;
    end else begin
      bit hit, cw, bad;
      logic [1:0] idx;
      hit = (host_addr[15:4] == B[15:4]);
      idx = host_addr[3:2];
      m_rv = host_rd_en;
      if (host_rd_en)
        case (idx)
          2'd0: m_hrdata = hit ? m_cmd() : 0;
          2'd1: m_hrdata = hit ? m_addr : 0;
          2'd2: m_hrdata = hit ? m_rdata : 0;
          default: m_hrdata = hit ? m_wdata : 0;
        endcase
      cw = host_wr_en && hit && idx == 0;
      bad = (m_addr > 32'hFFF) || (m_addr % 4 != 0);
      if (m_st == 0 && cw && host_wdata[1:0] != 0) begin
        m_op = host_wdata[1:0];
        if (m_op == 2'b11) m_st = 2;
        else if (bad) begin m_st = 2; if (m_op == 2'b01) m_rdata = 0; end
        else begin
          m_st = 1; m_req = 1; m_pwe = m_op[1]; m_paddr = m_addr[11:0]; m_pwdata = m_wdata;
        end
      end else if (m_st == 1 && priv_ack) begin
        m_st = 2; m_req = 0;
        if (m_op == 2'b01) m_rdata = priv_rdata;
      end else if (m_st == 2 && cw && host_wdata[1:0] == 0) begin
        m_st = 0; m_op = 0;
      end
      if (host_wr_en && hit && idx == 1) m_addr = host_wdata;
      if (host_wr_en && hit && idx == 3) m_wdata = host_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1 rvalid", {31'd0, host_rvalid}, {31'd0, m_rv});
      if (m_rv) chk("R2 host read data", host_rdata, m_hrdata);
      chk("R10 request", {31'd0, priv_req}, {31'd0, m_req});
      if (m_req) begin
        chk("R3 R4 write flag", {31'd0, priv_we}, {31'd0, m_pwe});
        chk("R3 R4 address", {20'd0, priv_addr}, {20'd0, m_paddr});
        chk("R4 write data", priv_wdata, m_pwdata);
      end
    end
  end

  task automatic hw(input logic [15:0] a, input logic [31:0] d);
    host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic hr(input logic [15:0] a, output logic [31:0] d);
    host_rd_en = 1; host_addr = a;
    @(negedge clk);
    host_rd_en = 0;
    d = host_rdata;
  endtask

  task automatic poll_ack(output logic [31:0] c);
    c = 0;
    for (int i = 0; i < 100; i++) begin
      hr(B, c);
      if (c[2]) break;
    end
  endtask

  initial begin
    logic [31:0] v, c;
    int rc;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE0000 | i;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    hr(B, v);      chk("R2 reset command", v, 0);
    hr(B + 8, v);  chk("R9 reset read data", v, 0);

    // R4 write
    hw(B + 12, 32'h12345678); hw(B + 4, 32'h10); hw(B, 32'h2);
    poll_ack(c);   chk("R4 ack after write", c, 32'h6);
    chk("R4 storage updated", mem[4], 32'h12345678);
    hw(B, 0);
    hr(B, v);      chk("R5 clear returns zero", v, 0);

    // R3 read
    hw(B + 4, 32'h10); hw(B, 32'h1);
    poll_ack(c);   chk("R3 ack after read", c, 32'h5);
    hr(B + 8, v);  chk("R3 read data", v, 32'h12345678);
    repeat (5) @(negedge clk);
    hr(B, v);      chk("R5 ack held", v, 32'h5);
    hr(B + 8, v);  chk("R5 read data held", v, 32'h12345678);
    hw(B, 32'h2);
    hr(B, v);      chk("R6 command ignored while ack set", v, 32'h5);
    hw(B + 8, 32'hFFFF0000);
    hr(B + 8, v);  chk("R9 read data write ignored", v, 32'h12345678);
    hw(B, 0);
    hr(B, v);      chk("R5 idle after clear", v, 0);

    // R6 command during busy
    fixed_lat = 8;
    hw(B + 4, 32'h20); hw(B + 12, 32'hAAAA5555); hw(B, 32'h1);
    hw(B, 32'h2);
    hr(B, v);      chk("R6 busy command unchanged", v, 32'h1);
    poll_ack(c);   chk("R6 ack for original read", c, 32'h5);
    hr(B + 8, v);  chk("R6 read data", v, 32'hC0DE0008);
    chk("R6 no write performed", mem[8], 32'hC0DE0008);
    hw(B, 0);

    // collision: completion and command write on the same edge
    fixed_lat = 2;
    rc = req_count;
    hw(B + 4, 32'h24); hw(B, 32'h1);
    for (int i = 0; i < 8; i++) hw(B, 32'h2);
    hr(B, v);      chk("R6 collision ack set", v, 32'h5);
    hr(B + 8, v);  chk("R3 collision read data", v, 32'hC0DE0009);
    chk("R10 collision single request", req_count - rc, 1);
    hw(B, 0);
    fixed_lat = -1;

    // R7 out of range and misaligned
    rc = req_count;
    hw(B + 4, 32'h1000); hw(B, 32'h1);
    hr(B, v);      chk("R7 immediate ack", v, 32'h5);
    hr(B + 8, v);  chk("R7 read returns zero", v, 0);
    hw(B, 0);
    hw(B + 4, 32'h6); hw(B + 12, 32'h77); hw(B, 32'h2);
    hr(B, v);      chk("R7 misaligned ack", v, 32'h6);
    chk("R7 misaligned write dropped", mem[1], 32'hC0DE0001);
    chk("R7 no request", req_count - rc, 0);
    hw(B, 0);

    // R8 both bits, after a good read
    hw(B + 4, 32'h30); hw(B, 32'h1); poll_ack(c); hw(B, 0);
    rc = req_count;
    hw(B, 32'h3);
    hr(B, v);      chk("R8 both bits ack", v, 32'h7);
    hr(B + 8, v);  chk("R8 read data kept", v, 32'hC0DE000C);
    chk("R8 no request", req_count - rc, 0);
    hw(B, 0);

    // R1 outside window
    hw(16'h0504, 32'h44);
    hr(16'h0504, v); chk("R1 outside read zero", v, 0);
    hr(B + 4, v);    chk("R1 address reg unchanged", v, 32'h30);

    // random traffic against the model
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a;
      a = {20'd0, 12'($urandom_range(0, 1023) * 4)};
      if (k % 7 == 3) a = a + 1;
      hw(B + 12, $urandom); hw(B + 4, a); hw(B, (k % 2) ? 32'h2 : 32'h1);
      poll_ack(c); chk("R2 random ack", {31'd0, c[2]}, 1);
      hw(B, 0);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule